// File: doc/BRIEF.md
# Dual-Lane Packed Dot-Product Engine

This block evaluates a dot product, or one output of an FIR filter, from a stream of 32-bit word pairs. Each word carries two signed 16-bit elements. In every accepted cycle the coefficient word and the data word feed two multipliers at once: one for the low halves and one for the high halves. Products from the low halves (even-indexed terms) collect in one accumulator. Products from the high halves (odd-indexed terms) collect in a second accumulator. The two accumulators are added only once, at the end.

A job begins with a start strobe that carries the number of word pairs to consume. That count is half the number of taps, so a four-tap filter needs two pairs. Words are taken only in cycles where the valid input is high, so the source may stall between words. After the last pair, the product passes through one register stage into the accumulators. The even and odd sums are then added, and the low 16 bits of that total appear on the result port together with a one-cycle done pulse. A mode input, sampled at start, chooses how overflow is handled. In wrap mode the 40-bit accumulators wrap around. In saturating mode every addition is clamped to the signed 40-bit range.

Top module: `pkdot_engine`

## Requirements
- R1: While reset is low at a clock edge, and in the cycle after, busy and done are 0 and result is 0.
- R2: For each accepted pair, bits 15:0 of the coefficient word and bits 15:0 of the data word are multiplied as signed 16-bit values, and the product is added to the even accumulator. Bits 31:16 of the two words are multiplied the same way, and that product goes to the odd accumulator.
- R3: The result is bits 15:0 of the sum of the even and odd accumulators.
- R4: A job consumes exactly pair_count words. A word counts only in a cycle where busy and in_valid are both high, and cycles with in_valid low stall the job without changing its result.
- R5: Done rises 2 clock edges after the edge that accepts the last word. With pair_count 0, done rises 2 edges after the start edge and the result is 0.
- R6: Done is high for exactly one cycle, and the result holds its value until the next done.
- R7: A start strobe raised while busy is high is ignored.
- R8: In_valid and the word inputs have no effect while busy is low.
- R9: With sat_mode 0 sampled at start, the accumulators and the final sum wrap modulo 2^40 in two's complement.
- R10: With sat_mode 1 sampled at start, every accumulation and the final sum are clamped to the range -2^39 to 2^39-1.
- R11: Busy rises on the edge that accepts a start strobe while idle, and it is low in the cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a job when the block is idle |
| pair_count | input | 16 | Number of word pairs in the job (half the tap count) |
| sat_mode | input | 1 | 1 = saturating 40-bit accumulation, 0 = wrapping |
| in_valid | input | 1 | Qualifies coef_word and data_word |
| coef_word | input | 32 | Two packed signed coefficients; element n in bits 15:0 |
| data_word | input | 32 | Two packed signed samples; element n in bits 15:0 |
| busy | output | 1 | A job is in progress |
| result | output | 16 | Low 16 bits of the combined sum; held until the next job ends |
| done | output | 1 | One-cycle pulse when result is updated |

## Verification
Every job has one result, and it is due exactly two clock edges after the edge that accepts its last word pair (or after the start edge when the count is zero). The driver notes the cycle in which it presents that last word and pushes the expected value with a due cycle of three edges later, measured from the falling edge on which it drove. The monitor samples at falling edges. When done appears, it compares both the value and the cycle against the head of the queue, and a done that arrives with an empty queue fails. Hold, stall, stray-start and idle-input cases are checked on the ports between jobs or inside them, so an early, late or extra done shows up as a mismatch.

// File: rtl/pkdot_pkg.sv
// Package: shared state encoding for the packed dot-product engine.
// Assumes nothing beyond being compiled before the modules that import it.
package pkdot_pkg;

    // Sequencer states: idle, consuming words, draining the product stage, combining.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_COMB  = 2'd3
    } pk_state_e;

endpackage

// File: rtl/pkdot_ctrl.sv
// Module: pkdot_ctrl
// Sequencer for one dot-product job. Accepts start only when idle, latches the
// pair count and the overflow mode, counts accepted words down to zero, then
// waits one cycle for the product register and one cycle to combine.
// Assumes: start and in_valid are synchronous to clk.
module pkdot_ctrl
    import pkdot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] pair_count,
    input  logic             sat_mode,
    input  logic             in_valid,
    output logic             take,
    output logic             clear,
    output logic             fire,
    output logic             busy,
    output logic             sat_q
);

    pk_state_e        state;
    logic [CNT_W-1:0] left_q;

    // Purpose: advance the job state, the remaining-pair count and the latched mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            left_q <= '0;
            sat_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        sat_q  <= sat_mode;
                        left_q <= pair_count;
                        state  <= (pair_count == '0) ? ST_DRAIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (in_valid) begin
                        left_q <= left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            state <= ST_DRAIN;
                        end
                    end
                end
                ST_DRAIN: state <= ST_COMB;
                ST_COMB:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode the per-cycle strobes for the datapath.
    always_comb begin
        take  = (state == ST_RUN) && in_valid;
        clear = (state == ST_IDLE) && start;
        fire  = (state == ST_COMB);
        busy  = (state != ST_IDLE);
    end

endmodule

// File: rtl/pkdot_lane_mul.sv
// Module: pkdot_lane_mul
// A row of signed halfword multipliers, one per packed lane, registered once.
// Lane l takes bits [l*HALF_W +: HALF_W] of both operand words.
// Assumes: the operands are valid whenever take is high.
module pkdot_lane_mul #(
    parameter int HALF_W = 16,
    parameter int LANES  = 2,
    localparam int WORD_W = LANES * HALF_W,
    localparam int PROD_W = 2 * HALF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take,
    input  logic [WORD_W-1:0]            coef_word,
    input  logic [WORD_W-1:0]            data_word,
    output logic [LANES-1:0][PROD_W-1:0] prod_q,
    output logic                         prod_vld
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [HALF_W-1:0] op_c;
        logic signed [HALF_W-1:0] op_d;
        logic signed [PROD_W-1:0] prod_c;

        // Purpose: split the lane's halfwords and form the full-width signed product.
        always_comb begin
            op_c   = coef_word[l*HALF_W +: HALF_W];
            op_d   = data_word[l*HALF_W +: HALF_W];
            prod_c = op_c * op_d;
        end

        // Purpose: register the lane product when a word pair is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod_q[l] <= '0;
            end else if (take) begin
                prod_q[l] <= prod_c;
            end
        end
    end

    // Purpose: mark which register contents are fresh products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_vld <= 1'b0;
        end else begin
            prod_vld <= take;
        end
    end

endmodule

// File: rtl/pkdot_accum.sv
// Module: pkdot_accum
// One extended-precision accumulator. It adds a sign-extended product each
// valid cycle and either wraps or clamps at the signed ACC_W range.
// Assumes: ACC_W > PROD_W, and clear has priority over add_en.
module pkdot_accum #(
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     add_en,
    input  logic                     sat_en,
    input  logic signed [PROD_W-1:0] prod,
    output logic signed [ACC_W-1:0]  acc_q
);

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W:0]   sum_ext;
    logic signed [ACC_W-1:0] acc_next;

    // Purpose: one-bit-wider sum, then wrap or clamp by mode.
    always_comb begin
        sum_ext = acc_q + prod;
        if (sat_en && (sum_ext[ACC_W] != sum_ext[ACC_W-1])) begin
            acc_next = sum_ext[ACC_W] ? ACC_MIN : ACC_MAX;
        end else begin
            acc_next = sum_ext[ACC_W-1:0];
        end
    end

    // Purpose: clear on job start, otherwise accumulate fresh products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (add_en) begin
            acc_q <= acc_next;
        end
    end

endmodule

// File: rtl/pkdot_combine.sv
// Module: pkdot_combine
// Final step: adds the even and odd accumulators (with the same wrap or clamp
// rule), registers the low OUT_W bits and pulses done.
// Assumes: fire is high for one cycle per job.
module pkdot_combine #(
    parameter int ACC_W = 40,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic                    sat_en,
    input  logic signed [ACC_W-1:0] acc_even,
    input  logic signed [ACC_W-1:0] acc_odd,
    output logic [OUT_W-1:0]        result_q,
    output logic                    done_q
);

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W:0]   total_ext;
    logic signed [ACC_W-1:0] total;

    // Purpose: sum both lanes and apply the job's overflow rule.
    always_comb begin
        total_ext = acc_even + acc_odd;
        if (sat_en && (total_ext[ACC_W] != total_ext[ACC_W-1])) begin
            total = total_ext[ACC_W] ? ACC_MIN : ACC_MAX;
        end else begin
            total = total_ext[ACC_W-1:0];
        end
    end

    // Purpose: capture the output word and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= fire;
            if (fire) begin
                result_q <= total[OUT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pkdot_engine.sv
// Module: pkdot_engine (top)
// Two-lane packed dot-product engine: a sequencer, a registered lane multiplier
// row, one accumulator per lane (even = low half, odd = high half) and a final
// combine stage.
// Assumes: the word source holds coef_word/data_word steady while in_valid is high.
module pkdot_engine #(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40,
    parameter int CNT_W  = 16,
    localparam int LANES  = 2,
    localparam int WORD_W = LANES * HALF_W,
    localparam int PROD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  pair_count,
    input  logic              sat_mode,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] coef_word,
    input  logic [WORD_W-1:0] data_word,
    output logic              busy,
    output logic [HALF_W-1:0] result,
    output logic              done
);

    logic                          take;
    logic                          clear;
    logic                          fire;
    logic                          sat_q;
    logic [LANES-1:0][PROD_W-1:0]  prod_q;
    logic                          prod_vld;
    logic [LANES-1:0][ACC_W-1:0]   acc_q;

    pkdot_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pair_count (pair_count),
        .sat_mode   (sat_mode),
        .in_valid   (in_valid),
        .take       (take),
        .clear      (clear),
        .fire       (fire),
        .busy       (busy),
        .sat_q      (sat_q)
    );

    pkdot_lane_mul #(
        .HALF_W (HALF_W),
        .LANES  (LANES)
    ) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .coef_word (coef_word),
        .data_word (data_word),
        .prod_q    (prod_q),
        .prod_vld  (prod_vld)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_acc
        logic signed [ACC_W-1:0] acc_l;

        pkdot_accum #(
            .PROD_W (PROD_W),
            .ACC_W  (ACC_W)
        ) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear),
            .add_en (prod_vld),
            .sat_en (sat_q),
            .prod   (prod_q[l]),
            .acc_q  (acc_l)
        );

        // Purpose: gather the lane accumulators into one array.
        always_comb acc_q[l] = acc_l;
    end

    pkdot_combine #(
        .ACC_W (ACC_W),
        .OUT_W (HALF_W)
    ) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .sat_en   (sat_q),
        .acc_even (acc_q[0]),
        .acc_odd  (acc_q[1]),
        .result_q (result),
        .done_q   (done)
    );

endmodule

// File: rtl/pkdot_engine_chk.sv
// Module: pkdot_engine_chk
// Port-level protocol checks for pkdot_engine, attached with bind below.
// Assumes: the same synchronous active-low reset as the engine.
module pkdot_engine_chk #(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [HALF_W-1:0] result
);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R11
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

endmodule

bind pkdot_engine pkdot_engine_chk #(.HALF_W(HALF_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/pkdot_engine_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results with their due cycle,
// and the monitor pops and compares them when done is seen.
module pkdot_engine_test;

    localparam longint MAX40 = 64'sd549755813887;
    localparam longint MIN40 = -64'sd549755813888;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pair_count = '0;
    logic        sat_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] coef_word = '0;
    logic [31:0] data_word = '0;
    logic        busy;
    logic [15:0] result;
    logic        done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int jobs_issued = 0;
    int jobs_done = 0;
    logic [31:0] rng = 32'h1234_5678;

    logic [31:0] cw[$];
    logic [31:0] dw[$];
    logic [15:0] exp_r[$];
    int          exp_due[$];
    string       exp_tag[$];

    pkdot_engine uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pair_count (pair_count),
        .sat_mode   (sat_mode),
        .in_valid   (in_valid),
        .coef_word  (coef_word),
        .data_word  (data_word),
        .busy       (busy),
        .result     (result),
        .done       (done)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic longint fit40(input longint v, input bit sat);
        if (sat) begin
            if (v > MAX40) return MAX40;
            if (v < MIN40) return MIN40;
            return v;
        end
        return (v <<< 24) >>> 24;
    endfunction

    function automatic logic [31:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // Driver: model the job from cw/dw, push expectation, drive the stimulus.
    task automatic run_job(input bit sat, input int gap, input int poke_at, input string tag);
        longint ev = 0;
        longint od = 0;
        longint tot;
        int n = cw.size();
        for (int i = 0; i < n; i++) begin
            ev = fit40(ev + longint'($signed(cw[i][15:0])) * longint'($signed(dw[i][15:0])), sat);
            od = fit40(od + longint'($signed(cw[i][31:16])) * longint'($signed(dw[i][31:16])), sat);
        end
        tot = fit40(ev + od, sat);
        @(negedge clk);
        start = 1'b1;
        pair_count = 16'(n);
        sat_mode = sat;
        exp_r.push_back(tot[15:0]);
        exp_tag.push_back(tag);
        jobs_issued++;
        if (n == 0) exp_due.push_back(cyc + 3);
        @(negedge clk);
        start = 1'b0;
        pair_count = 16'(7);
        sat_mode = ~sat;
        check(busy === 1'b1, "R11", "busy after start", longint'(busy), 1);
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && (i % gap) == 1) begin
                in_valid = 1'b0;
                coef_word = next_rand();
                data_word = next_rand();
                @(negedge clk);
            end
            in_valid = 1'b1;
            coef_word = cw[i];
            data_word = dw[i];
            if (i == poke_at) begin
                start = 1'b1;
                pair_count = 16'd1;
            end
            if (i == n - 1) exp_due.push_back(cyc + 3);
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0;
        coef_word = next_rand();
        data_word = next_rand();
        do @(negedge clk); while (jobs_done != jobs_issued);
        @(negedge clk);
    endtask

    // Monitor: compare each done against the queue head (value and cycle).
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_r.size() == 0) begin
                check(1'b0, "R6", "unexpected done", longint'(result), 0);
            end else begin
                automatic logic [15:0] er = exp_r.pop_front();
                automatic int          ed = exp_due.pop_front();
                automatic string       tg = exp_tag.pop_front();
                check(result === er, tg, "result", longint'(result), longint'(er));
                check(cyc == ed, "R5", "done cycle", longint'(cyc), longint'(ed));
                check(busy === 1'b0, "R11", "busy at done", longint'(busy), 0);
                jobs_done++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && done === 1'b0 && result === 16'h0, "R1", "reset outputs",
              longint'({busy, done, result}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && result === 16'h0, "R1", "after reset",
              longint'({busy, done, result}), 0);

        // R2/R3: four-tap filter, taps 2,3,4,5 on samples 10,-20,30,-40
        cw = '{{16'sd3, 16'sd2}, {16'sd5, 16'sd4}};
        dw = '{{-16'sd20, 16'sd10}, {-16'sd40, 16'sd30}};
        dw = '{{16'hFFEC, 16'd10}, {16'hFFD8, 16'd30}};
        run_job(1'b0, 0, -1, "R3");

        // R2: odd lane only (low halves zero), routes through the high halves
        cw.delete(); dw.delete();
        for (int i = 0; i < 8; i++) begin
            cw.push_back({16'sd7, 16'h0});
            dw.push_back({16'hFFF7, 16'h0});
        end
        run_job(1'b0, 0, -1, "R2");

        // R4: mixed signs with stall cycles
        cw.delete(); dw.delete();
        for (int i = 0; i < 12; i++) begin
            cw.push_back(next_rand());
            dw.push_back(next_rand());
        end
        run_job(1'b0, 3, -1, "R4");

        // R6: result holds after done
        held = result;
        repeat (5) @(negedge clk);
        check(result === held && done === 1'b0, "R6", "held result", longint'(result), longint'(held));

        // R8: words while idle have no effect
        in_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            coef_word = next_rand();
            data_word = next_rand();
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(result === held && busy === 1'b0, "R8", "idle words ignored", longint'(result), longint'(held));

        // R5: zero-count job
        cw.delete(); dw.delete();
        run_job(1'b0, 0, -1, "R5");

        // R7: stray start in mid-job
        cw.delete(); dw.delete();
        for (int i = 0; i < 10; i++) begin
            cw.push_back(next_rand());
            dw.push_back(next_rand());
        end
        run_job(1'b1, 0, 4, "R7");

        // R9/R10: positive overflow, both modes
        cw.delete(); dw.delete();
        for (int i = 0; i < 520; i++) begin
            cw.push_back(32'h8000_8000);
            dw.push_back(32'h8000_8000);
        end
        run_job(1'b0, 0, -1, "R9");
        run_job(1'b1, 0, -1, "R10");

        // R9/R10: negative overflow, both modes
        cw.delete(); dw.delete();
        for (int i = 0; i < 600; i++) begin
            cw.push_back(32'h8000_8000);
            dw.push_back(32'h7FFF_7FFF);
        end
        run_job(1'b0, 0, -1, "R9");
        run_job(1'b1, 0, -1, "R10");

        // R10: saturating mode without overflow matches plain arithmetic
        cw.delete(); dw.delete();
        for (int i = 0; i < 16; i++) begin
            cw.push_back(next_rand());
            dw.push_back(next_rand());
        end
        run_job(1'b1, 2, -1, "R10");

        repeat (4) @(negedge clk);
        check(exp_r.size() == 0, "R5", "pending results", exp_r.size(), 0);
        finish_run();
    end

endmodule